// File: doc/BRIEF.md
# Interrupt Request Aggregator with Down-Counting Timer

This block gathers single-cycle event pulses from the surrounding units and latches each into an interrupt-request bit. A per-source enable mask decides which pending requests count toward a combined status bit and toward an interrupt pin. The pin is a registered copy of that status. Software clears a request by writing ones to it. The block keeps no event history beyond the latched bit.

One of the sources is a built-in 8-bit down-counter. It decrements once per prescaled tick while its run input is high. When it steps from one, it either stops at zero or reloads from a separate reload value, and in both cases it raises the timer request. The transmit request is shared by three events: the transmitter leaving data for its end-of-frame pattern, CRC completion, and completion of a non-volatile write. Receive-end, command-to-idle and the two FIFO level alerts each have a bit of their own.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every request bit, `irq_status`, `irq_pin` and `tmr_value` are zero.
- R2: `tmr_load` writes `tmr_load_val` into the counter and restarts the prescaler. Load takes priority over counting. While `tmr_run` is high and no load is present, the counter decrements once every TICK_DIV cycles. While `tmr_run` is low, the counter holds its value.
- R3: When `tmr_auto` is low and a tick finds the counter at one, the counter goes to zero and request bit 0 (timer) is set. The counter then stays at zero until the next load.
- R4: When `tmr_auto` is high and a tick finds the counter at one, the counter takes `tmr_reload_val` instead of zero, and request bit 0 is set.
- R5: Request bit 1 (transmit) is set by `ev_tx_eof`, by `ev_crc_ready` or by `ev_nv_done`, each on its own.
- R6: Request bit 2 is set by `ev_rx_end`, bit 3 by `ev_cmd_idle`, bit 4 by `ev_fifo_hi` and bit 5 by `ev_fifo_lo`. No event sets any other bit.
- R7: Request bits stay set until cleared. A cycle with `clr_wr` high clears exactly the bits that are one in `clr_mask`.
- R8: If a set event and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R9: `irq_status` is the OR of `irq_req & irq_en` in the same cycle. `irq_pin` equals the value `irq_status` had one cycle earlier.
- R10: A pending request whose enable bit is zero stays visible on `irq_req` but raises neither `irq_status` nor `irq_pin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_load | input | 1 | Load pulse for the counter |
| tmr_load_val | input | 8 | Value written by a load |
| tmr_reload_val | input | 8 | Value taken after the one-step when auto-restart is on |
| tmr_auto | input | 1 | Auto-restart enable |
| tmr_run | input | 1 | Counter runs while high |
| ev_tx_eof | input | 1 | Transmitter moved from data to end-of-frame |
| ev_crc_ready | input | 1 | CRC unit finished the buffered data |
| ev_nv_done | input | 1 | Non-volatile write completed |
| ev_rx_end | input | 1 | End of received data |
| ev_cmd_idle | input | 1 | Command finished, back to idle |
| ev_fifo_hi | input | 1 | FIFO high-level alert |
| ev_fifo_lo | input | 1 | FIFO low-level alert |
| irq_en | input | 6 | Per-source enable mask |
| clr_wr | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 6 | Bits to clear when `clr_wr` is high |
| irq_req | output | 6 | Latched request bits (0 timer, 1 tx, 2 rx, 3 idle, 4 fifo hi, 5 fifo lo) |
| irq_status | output | 1 | Any enabled request pending |
| irq_pin | output | 1 | Registered interrupt pin |
| tmr_value | output | 8 | Current counter value |

## Verification
The bench builds the block with an 8-bit counter and TICK_DIV set to 3. With that divider, a full one-to-zero step or one-to-reload step completes within a handful of cycles. This lets the bench cross the stop-at-zero case and the reload case many times during random loads, and lets those crossings coincide with clears, enable changes and stops of the run input.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC  = 6;
  localparam int SRC_TMR  = 0;
  localparam int SRC_TX   = 1;
  localparam int SRC_RX   = 2;
  localparam int SRC_IDLE = 3;
  localparam int SRC_FHI  = 4;
  localparam int SRC_FLO  = 5;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_timer.sv
module irq_timer #(
  parameter int TMR_W    = 8,
  parameter int TICK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic [TMR_W-1:0] reload_val,
  input  logic             auto_rst,
  input  logic             run,
  output logic [TMR_W-1:0] cnt,
  output logic             fire
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PMAX = PW'(TICK_DIV - 1);
  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  logic [PW-1:0] presc;
  logic          tick;

  assign tick = run && !load && (presc == PMAX);
  assign fire = tick && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc <= '0;
    end else if (load || !run || presc == PMAX) begin
      presc <= '0;
    end else begin
      presc <= presc + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick && cnt != '0) begin
      if (cnt == ONE) cnt <= auto_rst ? reload_val : '0;
      else            cnt <= cnt - ONE;
    end
  end

  // R3: the one-step with auto-restart off lands on zero
  a_r3_stop_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !auto_rst) |=> (cnt == '0));
  // R3: a zero count holds until a load arrives
  a_r3_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load) |=> (cnt == '0));
  // R4: the one-step with auto-restart on lands on the reload value
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && auto_rst) |=> (cnt == $past(reload_val)));
  // R2: no counting while stopped
  a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt));
endmodule

// File: rtl/irq_req_bit.sv
module irq_req_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set | (q & ~clr);
  end

  // R8: a set event wins over a same-cycle clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  // R7: a pending bit stays set without a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr) |=> q);
  // R7: a clear without a set empties the bit
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_pkg::*;
#(
  parameter int TMR_W    = 8,
  parameter int TICK_DIV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tmr_load,
  input  logic [TMR_W-1:0]   tmr_load_val,
  input  logic [TMR_W-1:0]   tmr_reload_val,
  input  logic               tmr_auto,
  input  logic               tmr_run,
  input  logic               ev_tx_eof,
  input  logic               ev_crc_ready,
  input  logic               ev_nv_done,
  input  logic               ev_rx_end,
  input  logic               ev_cmd_idle,
  input  logic               ev_fifo_hi,
  input  logic               ev_fifo_lo,
  input  logic [NUM_SRC-1:0] irq_en,
  input  logic               clr_wr,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] irq_req,
  output logic               irq_status,
  output logic               irq_pin,
  output logic [TMR_W-1:0]   tmr_value
);
  logic     tmr_fire;
  src_vec_t set_vec;
  src_vec_t clr_vec;

  irq_timer #(.TMR_W(TMR_W), .TICK_DIV(TICK_DIV)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (tmr_load),
    .load_val   (tmr_load_val),
    .reload_val (tmr_reload_val),
    .auto_rst   (tmr_auto),
    .run        (tmr_run),
    .cnt        (tmr_value),
    .fire       (tmr_fire)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_TMR]  = tmr_fire;
    set_vec[SRC_TX]   = ev_tx_eof | ev_crc_ready | ev_nv_done;
    set_vec[SRC_RX]   = ev_rx_end;
    set_vec[SRC_IDLE] = ev_cmd_idle;
    set_vec[SRC_FHI]  = ev_fifo_hi;
    set_vec[SRC_FLO]  = ev_fifo_lo;
  end

  assign clr_vec = clr_wr ? clr_mask : '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irq_req_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_vec[i]),
      .clr   (clr_vec[i]),
      .q     (irq_req[i])
    );
  end

  assign irq_status = |(irq_req & irq_en);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_pin <= 1'b0;
    else        irq_pin <= irq_status;
  end

  // R9: the pin trails the status by one cycle
  a_r9_pin_lag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_pin == $past(irq_status)));
  // R5: any transmit-side event raises the shared bit
  a_r5_tx_shared: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_eof || ev_crc_ready || ev_nv_done) |=> irq_req[SRC_TX]);
  // R10: masked requests never reach the status
  a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_req & irq_en) == '0) |-> !irq_status);
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  localparam int W = 8;
  localparam int DIV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmr_load = 0, tmr_auto = 0, tmr_run = 0;
  logic [W-1:0] tmr_load_val = '0, tmr_reload_val = '0;
  logic ev_tx_eof = 0, ev_crc_ready = 0, ev_nv_done = 0, ev_rx_end = 0;
  logic ev_cmd_idle = 0, ev_fifo_hi = 0, ev_fifo_lo = 0;
  logic [5:0] irq_en = '0, clr_mask = '0;
  logic clr_wr = 0;
  logic [5:0] irq_req;
  logic irq_status, irq_pin;
  logic [W-1:0] tmr_value;

  int n_chk = 0, n_bad = 0;

  // reference state
  int m_cnt = 0, m_presc = 0;
  logic [5:0] m_req = '0;
  logic m_pin = 0;

  always #2.5 clk = ~clk;

  irq_aggregator #(.TMR_W(W), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_load(tmr_load), .tmr_load_val(tmr_load_val),
    .tmr_reload_val(tmr_reload_val), .tmr_auto(tmr_auto), .tmr_run(tmr_run),
    .ev_tx_eof(ev_tx_eof), .ev_crc_ready(ev_crc_ready), .ev_nv_done(ev_nv_done),
    .ev_rx_end(ev_rx_end), .ev_cmd_idle(ev_cmd_idle), .ev_fifo_hi(ev_fifo_hi),
    .ev_fifo_lo(ev_fifo_lo), .irq_en(irq_en), .clr_wr(clr_wr), .clr_mask(clr_mask),
    .irq_req(irq_req), .irq_status(irq_status), .irq_pin(irq_pin), .tmr_value(tmr_value)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic exp_status(logic [5:0] r, logic [5:0] e);
    return |(r & e);
  endfunction

  // advance the reference by one clock from the current inputs
  task automatic model_step();
    logic tick, fire;
    logic [5:0] setv;
    tick = tmr_run && !tmr_load && (m_presc == DIV - 1);
    fire = tick && (m_cnt == 1);
    m_pin = exp_status(m_req, irq_en);
    setv = {ev_fifo_lo, ev_fifo_hi, ev_cmd_idle, ev_rx_end,
            ev_tx_eof | ev_crc_ready | ev_nv_done, fire};
    m_req = setv | (m_req & ~(clr_wr ? clr_mask : 6'd0));
    if (tmr_load) m_cnt = int'(tmr_load_val);
    else if (tick && m_cnt != 0) m_cnt = (m_cnt == 1) ? (tmr_auto ? int'(tmr_reload_val) : 0) : m_cnt - 1;
    if (tmr_load || !tmr_run || m_presc == DIV - 1) m_presc = 0;
    else m_presc = m_presc + 1;
  endtask

  task automatic step(string tag);
    model_step();
    @(posedge clk); #1;
    chk({tag, " cnt"}, int'(tmr_value), m_cnt);
    chk({tag, " req"}, int'(irq_req), int'(m_req));
    chk({tag, " status"}, int'(irq_status), int'(exp_status(m_req, irq_en)));
    chk({tag, " pin"}, int'(irq_pin), int'(m_pin));
    @(negedge clk);
    tmr_load = 0; clr_wr = 0;
    {ev_tx_eof, ev_crc_ready, ev_nv_done, ev_rx_end, ev_cmd_idle, ev_fifo_hi, ev_fifo_lo} = '0;
  endtask

  initial begin
    #900000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    // R1: reset state
    chk("R1 req", int'(irq_req), 0);
    chk("R1 pin", int'(irq_pin), 0);
    chk("R1 cnt", int'(tmr_value), 0);
    @(negedge clk);

    // R2/R3: load 2, stop at zero
    irq_en = 6'h3F;
    tmr_load = 1; tmr_load_val = 8'd2; tmr_run = 1; tmr_auto = 0;
    step("R2");
    chk("R2 loaded", int'(tmr_value), 2);
    for (int k = 0; k < DIV; k++) step("R2");
    chk("R2 one tick", int'(tmr_value), 1);
    for (int k = 0; k < DIV; k++) step("R3");
    chk("R3 zero", int'(tmr_value), 0);
    chk("R3 timer bit", int'(irq_req[0]), 1);
    chk("R9 pin lags", int'(irq_pin), 0);
    step("R9");
    chk("R9 pin up", int'(irq_pin), 1);
    for (int k = 0; k < 3 * DIV; k++) step("R3");
    chk("R3 stays zero", int'(tmr_value), 0);

    // R2: stopped counter holds
    tmr_load = 1; tmr_load_val = 8'd9; step("R2");
    tmr_run = 0;
    for (int k = 0; k < 4 * DIV; k++) step("R2");
    chk("R2 hold", int'(tmr_value), 9);

    // R4: reload
    clr_wr = 1; clr_mask = 6'h3F; step("R7");
    chk("R7 all clear", int'(irq_req), 0);
    tmr_run = 1; tmr_auto = 1; tmr_reload_val = 8'd5;
    tmr_load = 1; tmr_load_val = 8'd1; step("R4");
    for (int k = 0; k < DIV; k++) step("R4");
    chk("R4 reload", int'(tmr_value), 5);
    chk("R4 timer bit", int'(irq_req[0]), 1);
    tmr_run = 0;

    // R5: three transmit sources separately
    clr_wr = 1; clr_mask = 6'h3F; step("R7");
    ev_tx_eof = 1; step("R5");
    chk("R5 eof", int'(irq_req), 2);
    clr_wr = 1; clr_mask = 6'h02; step("R5");
    ev_crc_ready = 1; step("R5");
    chk("R5 crc", int'(irq_req), 2);
    clr_wr = 1; clr_mask = 6'h02; step("R5");
    ev_nv_done = 1; step("R5");
    chk("R5 nv", int'(irq_req), 2);

    // R6: other sources
    ev_rx_end = 1; step("R6"); chk("R6 rx", int'(irq_req), 6);
    ev_cmd_idle = 1; step("R6"); chk("R6 idle", int'(irq_req), 14);
    ev_fifo_hi = 1; step("R6"); chk("R6 hi", int'(irq_req), 30);
    ev_fifo_lo = 1; step("R6"); chk("R6 lo", int'(irq_req), 62);

    // R7: selective clear
    clr_wr = 1; clr_mask = 6'h14; step("R7");
    chk("R7 selective", int'(irq_req), 6'h2A);
    // R8: set wins
    ev_rx_end = 1; clr_wr = 1; clr_mask = 6'h04; step("R8");
    chk("R8 set wins", int'(irq_req[2]), 1);

    // R10: masked
    irq_en = 6'h00; step("R10"); step("R10");
    chk("R10 status", int'(irq_status), 0);
    chk("R10 pin", int'(irq_pin), 0);
    chk("R10 visible", int'(irq_req), 6'h2E);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 19) == 0) begin
        tmr_load = 1; tmr_load_val = W'($urandom_range(0, 6));
      end
      if ($urandom_range(0, 29) == 0) tmr_auto = ~tmr_auto;
      if ($urandom_range(0, 29) == 0) tmr_reload_val = W'($urandom_range(0, 7));
      tmr_run = ($urandom_range(0, 9) != 0);
      ev_tx_eof    = ($urandom_range(0, 15) == 0);
      ev_crc_ready = ($urandom_range(0, 15) == 0);
      ev_nv_done   = ($urandom_range(0, 15) == 0);
      ev_rx_end    = ($urandom_range(0, 11) == 0);
      ev_cmd_idle  = ($urandom_range(0, 11) == 0);
      ev_fifo_hi   = ($urandom_range(0, 11) == 0);
      ev_fifo_lo   = ($urandom_range(0, 11) == 0);
      if ($urandom_range(0, 3) == 0) begin
        clr_wr = 1; clr_mask = 6'($urandom);
      end
      if ($urandom_range(0, 15) == 0) irq_en = 6'($urandom);
      step("R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule